// File: doc/BRIEF.md
# Idle-State Demotion and Promotion Filter

This block sits between the idle-state requests issued by the operating system and the controller that actually puts the package to sleep. Each request names a target idle state. State 0 means running, and larger numbers are deeper. The block measures how long every stay in a deep state lasts, counted in ticks of a slow timebase. It compares that stay with a programmable break-even residency for the requested state. A stay shorter than break-even costs more in entry and exit than it saves, so it is scored as a loss. A stay that reaches break-even is scored as a win.

A saturating loss counter accumulates this history. While the counter sits above a programmable threshold, deep requests are demoted to the deepest shallow state. Two things end a demotion. One is a programmable run of consecutive wins. The other is an idle stay that outlasts a timeout; in that case the block raises the grant to the requested state in the middle of the stay. The granted state is never deeper than the request. The sequencing of power gates is left to the downstream controller.

Top module: `idle_demote_filter`

## Requirements
- R1: After reset the grant is 0 (running), the block is in the running phase, and the loss counter and win streak are zero.
- R2: While running, a cycle with `enter_req` high and a nonzero `enter_state` enters the idle phase. From the next cycle the grant equals `enter_state`, unless R6 demotes it. A request for state 0 is ignored.
- R3: While idle, `wake` returns the grant to 0 on the next cycle. `wake` while running has no effect, and `enter_req` while idle has no effect.
- R4: The residency is the number of cycles with `tick` high after the entry cycle and before the wake cycle. It saturates at its maximum value. For a requested state of at least `DEEP_MIN`, the wake scores a loss when residency < `break_even[state]` and a win otherwise. Requests below `DEEP_MIN` are not scored.
- R5: A loss adds one to the loss counter, which saturates at 2^LOSS_W-1. A win subtracts one, with a floor of 0.
- R6: The block is demoted while the loss counter > `demote_thresh`. An entry to a state ≥ `DEEP_MIN` while demoted is granted state `DEEP_MIN-1`.
- R7: A loss resets the win streak and a win adds one to it. A win that brings the streak to at least `promote_runs` while demoted clears both the loss counter and the streak.
- R8: While idle, if the grant is shallower than a deep request and the residency is ≥ `idle_timeout`, the grant rises to the requested state on the next cycle. In that cycle the loss counter and streak are cleared. A `wake` in the same cycle takes precedence.
- R9: The grant never exceeds the requested state, and it is 0 while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Residency timebase pulse |
| enter_req | input | 1 | Operating-system idle entry request |
| enter_state | input | SW | Requested idle state |
| wake | input | 1 | Wake event ending the idle stay |
| break_even | input | NUM_STATES×RES_W | Break-even residency per state, in ticks |
| demote_thresh | input | LOSS_W | Loss count that must be exceeded to demote |
| promote_runs | input | STREAK_W | Consecutive wins needed to promote |
| idle_timeout | input | RES_W | Residency that promotes during an idle stay |
| grant_state | output | SW | Idle state granted downstream |

## Verification
The bench probes the exact break-even boundary with residencies of 9 and 10 ticks against a break-even of 10. A design that compared with the wrong inequality would score the wrong wake as a loss and would demote one entry early or late. The bench drives enough losses to saturate the loss counter, then proves that promotion follows three wins. A counter that wrapped instead of saturating would drop out of demotion too early, and missing streak logic would keep demoting. A long stay under demotion has to raise the grant part-way through the stay. Shallow-state bursts and stray `enter_req` or `wake` pulses must leave the grant untouched. Either fault would show up as a wrong grant against the cycle-level model.

// File: rtl/idlefilt_pkg.sv
package idlefilt_pkg;
   typedef enum logic {
      PH_RUN  = 1'b0,
      PH_IDLE = 1'b1
   } phase_e;
endpackage

// File: rtl/idlefilt_resid_timer.sv
module idlefilt_resid_timer #(
   parameter int RES_W      = 12,
   parameter bit TIMEOUT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic             tick,
   input  logic [RES_W-1:0] idle_timeout,
   output logic [RES_W-1:0] res_cnt,
   output logic             timed_out
);
   localparam logic [RES_W-1:0] RES_MAX = {RES_W{1'b1}};

   logic [RES_W-1:0] res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            res_q <= '0;
      else if (start)                        res_q <= '0;
      else if (run && tick && res_q != RES_MAX) res_q <= res_q + RES_W'(1);
   end

   assign res_cnt = res_q;

   generate
      if (TIMEOUT_EN) begin : g_tmo
         assign timed_out = run && (res_q >= idle_timeout);
      end else begin : g_no_tmo
         logic unused_tmo;
         assign unused_tmo = ^idle_timeout;
         assign timed_out  = 1'b0;
      end
   endgenerate

   p_res_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> res_q == '0);
   p_res_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !tick) |=> $stable(res_q));
   p_res_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && res_q == RES_MAX) |=> res_q == RES_MAX);
endmodule

// File: rtl/idlefilt_scorer.sv
module idlefilt_scorer #(
   parameter int LOSS_W   = 3,
   parameter int STREAK_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                eval,
   input  logic                loss_ev,
   input  logic                force_clr,
   input  logic [LOSS_W-1:0]   demote_thresh,
   input  logic [STREAK_W-1:0] promote_runs,
   output logic                demoted
);
   localparam logic [LOSS_W-1:0]   LOSS_MAX   = {LOSS_W{1'b1}};
   localparam logic [STREAK_W-1:0] STREAK_MAX = {STREAK_W{1'b1}};

   logic [LOSS_W-1:0]   loss_q;
   logic [STREAK_W-1:0] streak_q;
   logic [STREAK_W-1:0] streak_nx;
   logic                promote;

   assign demoted   = loss_q > demote_thresh;
   assign streak_nx = (streak_q == STREAK_MAX) ? streak_q : streak_q + STREAK_W'(1);
   assign promote   = demoted && (streak_nx >= promote_runs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loss_q   <= '0;
         streak_q <= '0;
      end else if (force_clr) begin
         loss_q   <= '0;
         streak_q <= '0;
      end else if (eval) begin
         if (loss_ev) begin
            if (loss_q != LOSS_MAX) loss_q <= loss_q + LOSS_W'(1);
            streak_q <= '0;
         end else if (promote) begin
            loss_q   <= '0;
            streak_q <= '0;
         end else begin
            if (loss_q != '0) loss_q <= loss_q - LOSS_W'(1);
            streak_q <= streak_nx;
         end
      end
   end

   p_loss_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && loss_ev && !force_clr && loss_q == LOSS_MAX) |=> loss_q == LOSS_MAX);
   p_loss_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && loss_ev && !force_clr && loss_q != LOSS_MAX) |=> loss_q == $past(loss_q) + LOSS_W'(1));
   p_win_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && !loss_ev && !force_clr && loss_q != '0) |=> loss_q < $past(loss_q));
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      force_clr |=> (loss_q == '0 && streak_q == '0));
   p_streak_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eval && loss_ev) |=> streak_q == '0);
endmodule

// File: rtl/idlefilt_grant_sel.sv
module idlefilt_grant_sel #(
   parameter int NUM_STATES = 4,
   parameter int DEEP_MIN   = 2,
   parameter int RES_W      = 12,
   localparam int SW        = $clog2(NUM_STATES)
) (
   input  logic [SW-1:0]                      enter_state,
   input  logic [SW-1:0]                      held_state,
   input  logic                               demoted,
   input  logic [NUM_STATES-1:0][RES_W-1:0]   break_even,
   output logic                               enter_deep,
   output logic                               held_deep,
   output logic [SW-1:0]                      entry_grant,
   output logic [RES_W-1:0]                   held_break_even
);
   localparam logic [SW-1:0] SHALLOW = SW'(DEEP_MIN - 1);

   logic [NUM_STATES-1:0] deep_mask;

   generate
      for (genvar s = 0; s < NUM_STATES; s++) begin : g_mask
         assign deep_mask[s] = (s >= DEEP_MIN);
      end
   endgenerate

   assign enter_deep      = deep_mask[enter_state];
   assign held_deep       = deep_mask[held_state];
   assign entry_grant     = (enter_deep && demoted) ? SHALLOW : enter_state;
   assign held_break_even = break_even[held_state];

   always_comb begin
      a_entry_le_req_r9: assert (entry_grant <= enter_state);
   end
endmodule

// File: rtl/idle_demote_filter.sv
module idle_demote_filter
   import idlefilt_pkg::*;
#(
   parameter int NUM_STATES = 4,
   parameter int DEEP_MIN   = 2,
   parameter int RES_W      = 12,
   parameter int LOSS_W     = 3,
   parameter int STREAK_W   = 3,
   parameter bit TIMEOUT_EN = 1'b1,
   localparam int SW        = $clog2(NUM_STATES)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             tick,
   input  logic                             enter_req,
   input  logic [SW-1:0]                    enter_state,
   input  logic                             wake,
   input  logic [NUM_STATES-1:0][RES_W-1:0] break_even,
   input  logic [LOSS_W-1:0]                demote_thresh,
   input  logic [STREAK_W-1:0]              promote_runs,
   input  logic [RES_W-1:0]                 idle_timeout,
   output logic [SW-1:0]                    grant_state
);
   localparam logic [SW-1:0] SHALLOW = SW'(DEEP_MIN - 1);

   initial begin
      if (NUM_STATES < 2 || NUM_STATES != (1 << SW))
         $fatal(1, "NUM_STATES must be a power of two of at least 2");
      if (DEEP_MIN < 1 || DEEP_MIN >= NUM_STATES)
         $fatal(1, "DEEP_MIN must lie in 1..NUM_STATES-1");
      if (RES_W < 2 || LOSS_W < 1 || STREAK_W < 1)
         $fatal(1, "counter widths too small");
   end

   phase_e            phase_q;
   logic [SW-1:0]     req_q;
   logic [SW-1:0]     grant_q;

   logic              demoted;
   logic              enter_deep, held_deep;
   logic [SW-1:0]     entry_grant;
   logic [RES_W-1:0]  held_be;
   logic [RES_W-1:0]  res_cnt;
   logic              timed_out;
   logic              idle, accept, wake_ok, eval, loss_ev, timeout_hit;

   assign idle        = (phase_q == PH_IDLE);
   assign accept      = !idle && enter_req && (enter_state != '0);
   assign wake_ok     = idle && wake;
   assign eval        = wake_ok && held_deep;
   assign loss_ev     = res_cnt < held_be;
   assign timeout_hit = timed_out && !wake && held_deep && (grant_q != req_q);

   idlefilt_grant_sel #(
      .NUM_STATES (NUM_STATES),
      .DEEP_MIN   (DEEP_MIN),
      .RES_W      (RES_W)
   ) u_sel (
      .enter_state     (enter_state),
      .held_state      (req_q),
      .demoted         (demoted),
      .break_even      (break_even),
      .enter_deep      (enter_deep),
      .held_deep       (held_deep),
      .entry_grant     (entry_grant),
      .held_break_even (held_be)
   );

   idlefilt_resid_timer #(
      .RES_W      (RES_W),
      .TIMEOUT_EN (TIMEOUT_EN)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (accept),
      .run          (idle),
      .tick         (tick),
      .idle_timeout (idle_timeout),
      .res_cnt      (res_cnt),
      .timed_out    (timed_out)
   );

   idlefilt_scorer #(
      .LOSS_W   (LOSS_W),
      .STREAK_W (STREAK_W)
   ) u_score (
      .clk           (clk),
      .rst_n         (rst_n),
      .eval          (eval),
      .loss_ev       (loss_ev),
      .force_clr     (timeout_hit),
      .demote_thresh (demote_thresh),
      .promote_runs  (promote_runs),
      .demoted       (demoted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_RUN;
         req_q   <= '0;
         grant_q <= '0;
      end else if (accept) begin
         phase_q <= PH_IDLE;
         req_q   <= enter_state;
         grant_q <= entry_grant;
      end else if (wake_ok) begin
         phase_q <= PH_RUN;
         req_q   <= '0;
         grant_q <= '0;
      end else if (timeout_hit) begin
         grant_q <= req_q;
      end
   end

   assign grant_state = grant_q;

   p_grant_le_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      grant_q <= req_q);
   p_run_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> grant_q == '0);
   p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wake_ok |=> (grant_q == '0 && phase_q == PH_RUN));
   p_idle_enter_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !wake && !timeout_hit) |=> $stable(grant_q));
   p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !enter_deep) |=> grant_q == $past(enter_state));
   p_demote_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && enter_deep && demoted) |=> grant_q == SHALLOW);
   p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_hit |=> grant_q == $past(req_q));
endmodule

// File: tb/idle_demote_filter_tb.sv
`timescale 1ns/1ps
module idle_demote_filter_tb;
   localparam int NS = 4, DM = 2, RW = 12, LW = 3, STW = 3;
   localparam int THR = 2, PRUNS = 3, TMO = 40;
   localparam int LMAX = 7, SMAX = 7, RMAX = 4095;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic tick_alt = 1'b0;
   logic enter_req = 1'b0;
   logic [1:0] enter_state = '0;
   logic wake = 1'b0;
   logic [NS-1:0][RW-1:0] be_cfg;
   logic [1:0] grant;

   int be_int [NS] = '{0, 20, 5, 10};
   int checks = 0, fails = 0;
   bit done = 1'b0;
   string tag = "R1";

   always #2 clk = ~clk;

   initial begin
      for (int i = 0; i < NS; i++) be_cfg[i] = RW'(be_int[i]);
   end

   idle_demote_filter #(
      .NUM_STATES (NS), .DEEP_MIN (DM), .RES_W (RW),
      .LOSS_W (LW), .STREAK_W (STW), .TIMEOUT_EN (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .tick (tick),
      .enter_req (enter_req), .enter_state (enter_state), .wake (wake),
      .break_even (be_cfg), .demote_thresh (LW'(THR)),
      .promote_runs (STW'(PRUNS)), .idle_timeout (RW'(TMO)),
      .grant_state (grant)
   );

   always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

   // behavioural reference model
   int m_idle = 0, m_req = 0, m_grant = 0, m_res = 0, m_loss = 0, m_streak = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_idle = 0; m_req = 0; m_grant = 0; m_res = 0; m_loss = 0; m_streak = 0;
      end else begin
         automatic bit dem  = m_loss > THR;
         automatic bit deep = m_req >= DM;
         automatic bit to   = m_idle && !wake && deep && m_grant < m_req && m_res >= TMO;
         automatic bit ev   = m_idle && wake && deep;
         automatic bit le   = m_res < be_int[m_req];
         automatic int est  = int'(enter_state);
         if (to) begin m_loss = 0; m_streak = 0; end
         else if (ev) begin
            if (le) begin
               if (m_loss < LMAX) m_loss++;
               m_streak = 0;
            end else begin
               automatic int s = (m_streak < SMAX) ? m_streak + 1 : m_streak;
               if (dem && s >= PRUNS) begin m_loss = 0; m_streak = 0; end
               else begin if (m_loss > 0) m_loss--; m_streak = s; end
            end
         end
         if (!m_idle && enter_req && est != 0) m_res = 0;
         else if (m_idle && tick && m_res < RMAX) m_res++;
         if (!m_idle) begin
            if (enter_req && est != 0) begin
               m_idle = 1; m_req = est;
               m_grant = (est >= DM && dem) ? DM - 1 : est;
            end
         end else if (wake) begin
            m_idle = 0; m_grant = 0; m_req = 0;
         end else if (to) m_grant = m_req;
      end
   end

   // per-cycle comparison against the model (R9 invariant included)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (int'(grant) != m_grant) begin
            fails++;
            $display("FAIL %s: grant=%0d expected %0d (model)", tag, grant, m_grant);
         end
         checks++;
         if (int'(grant) > m_req) begin
            fails++;
            $display("FAIL R9: grant=%0d expected at most %0d", grant, m_req);
         end
      end
   end

   task automatic expect_grant(input string t, input int exp);
      checks++;
      if (int'(grant) != exp) begin
         fails++;
         $display("FAIL %s: grant=%0d expected %0d", t, grant, exp);
      end
   endtask

   // enter state st, stay n cycles, wake; exp < 0 skips the entry check
   task automatic idle_run(input int st, input int n, input int exp, input string t);
      @(negedge clk); enter_req = 1'b1; enter_state = 2'(st);
      @(negedge clk); enter_req = 1'b0;
      if (exp >= 0) expect_grant(t, exp);
      repeat (n) @(negedge clk);
      wake = 1'b1;
      @(negedge clk); wake = 1'b0;
      expect_grant(t, 0);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      expect_grant("R1", 0);
      rst_n = 1'b1;
      @(negedge clk);
      expect_grant("R1", 0);

      // R2: state 0 ignored, shallow and deep entries granted as asked
      tag = "R2";
      enter_req = 1'b1; enter_state = 2'd0;
      @(negedge clk); enter_req = 1'b0;
      @(negedge clk); expect_grant("R2", 0);
      idle_run(1, 3, 1, "R2");
      idle_run(3, 20, 3, "R2");

      // R3: stray enter while idle, stray wake while running
      tag = "R3";
      @(negedge clk); enter_req = 1'b1; enter_state = 2'd2;
      @(negedge clk); enter_state = 2'd3;
      expect_grant("R3", 2);
      @(negedge clk); enter_req = 1'b0;
      expect_grant("R3", 2);
      repeat (8) @(negedge clk);
      wake = 1'b1;
      @(negedge clk); wake = 1'b0;
      expect_grant("R3", 0);
      wake = 1'b1;
      @(negedge clk); wake = 1'b0;
      @(negedge clk); expect_grant("R3", 0);

      // R4: break-even boundary 9 vs 10 ticks on state 3 (break-even 10)
      tag = "R4";
      for (int i = 0; i < 3; i++) idle_run(3, 9, 3, "R4");
      idle_run(3, 10, 1, "R4");
      idle_run(3, 10, 3, "R4");
      // shallow state 1 bursts are not scored
      for (int i = 0; i < 5; i++) idle_run(1, 2, 1, "R4");
      idle_run(3, 12, 3, "R4");

      // R5/R6/R7: saturate losses, then promote after a win streak
      tag = "R5"; tick_alt = 1'b1;
      for (int i = 0; i < 10; i++) idle_run(3, 2, -1, "R5");
      tag = "R6";
      idle_run(3, 30, 1, "R6");
      tag = "R5";
      idle_run(3, 30, 1, "R5");
      tag = "R7";
      idle_run(3, 30, 1, "R7");
      idle_run(3, 4, 3, "R7");

      // R8: promotion part-way through a long stay
      tag = "R8"; tick_alt = 1'b0;
      for (int i = 0; i < 3; i++) idle_run(3, 2, -1, "R8");
      @(negedge clk); enter_req = 1'b1; enter_state = 2'd3;
      @(negedge clk); enter_req = 1'b0;
      expect_grant("R6", 1);
      repeat (50) @(negedge clk);
      expect_grant("R8", 3);
      wake = 1'b1;
      @(negedge clk); wake = 1'b0;
      expect_grant("R8", 0);
      idle_run(3, 12, 3, "R8");

      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule